// File: doc/BRIEF.md
# Serial Command Decoder for a Position Counter

This block is the host-facing serial port of an up/down position counter. A host uses a 4-wire synchronous serial link (SPI, mode 0, slave only) to program two configuration bytes and a preset value, and to read back status and a captured copy of the counter. All three serial inputs are brought into the system clock domain through synchronizer flops. Every serial edge is then found by oversampling, so the whole block runs on one clock. The counter itself and its status byte live in a neighbouring block. This decoder sees their values on input buses and drives single-cycle clear and load strobes back to it.

A transfer starts when the select line falls and ends when it rises. The first byte is the instruction. Its top two bits choose an operation and the next three bits choose a register. Any data bytes come after it, MSB first. For the preset, counter and capture registers, the number of data bytes follows the width field held in configuration byte 1. The configuration and status registers always move a single byte. Reading the counter first captures it into the capture register and then shifts that captured value out. A select period carries only one instruction. Anything sent after the expected bytes is ignored until the select line is released and asserted again.

Top module: `qspi_cmd`

## Requirements
- R1: `miso` is high-impedance whenever `ss_n` is high. While selected, it drives 0 during the instruction byte and during every byte that is not read data.
- R2: Instruction bits 7:6 select the operation: 00 clear, 01 read, 10 write, 11 load. Bits 5:3 select the register: 001 cfg0, 010 cfg1, 011 preset, 100 counter, 101 capture, 110 status; 000 and 111 select nothing. Bits 2:0 have no effect.
- R3: `cfg1[1:0]` sets the wide-register byte count: 00 → 4, 01 → 3, 10 → 2, 11 → 1. The count is sampled when the instruction byte completes. The preset, counter and capture registers move that many data bytes; cfg0, cfg1, status and no-register move one. Data is MSB first on both lines. MOSI is sampled on a rising SCK edge, and MISO changes on a falling edge.
- R4: A write updates its register only when its last expected data byte arrives. An aborted write changes nothing. A preset write loads the received bytes zero-extended. Writes to the counter, capture, status or no register change nothing.
- R5: A counter read copies `cnt_in` into `snap` when the instruction byte completes, then shifts the low byte-count bytes of that value out.
- R6: Reading cfg0, cfg1, capture or status shifts out its current value. Reading preset or no register returns zero bytes.
- R7: Clear acts when the instruction byte completes. Cfg0 or cfg1 goes to 0. The counter gives one `cnt_clr` pulse, and status gives one `status_clr` pulse. Clearing preset, capture or no register changes nothing.
- R8: Load acts when the instruction byte completes. The counter gives one `cnt_load` pulse (the neighbour copies `preset` into the counter). Capture gets `snap` loaded from `cnt_in`. Load on any other register has no effect.
- R9: While read data is shifted out, MOSI has no effect. After the expected byte count, further bytes are ignored (MISO returns 0) until `ss_n` rises and falls again.
- R10: After reset, `cfg0`, `cfg1`, `preset` and `snap` are zero and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, high-impedance when unselected |
| cnt_in | input | CNT_BYTES*8 | Live counter value from the neighbour |
| status_in | input | 8 | Status byte from the neighbour |
| cfg0 | output | 8 | Configuration byte 0 |
| cfg1 | output | 8 | Configuration byte 1; bits 1:0 set the byte count |
| preset | output | CNT_BYTES*8 | Preset value |
| snap | output | CNT_BYTES*8 | Capture register |
| cnt_clr | output | 1 | One-cycle counter clear strobe |
| cnt_load | output | 1 | One-cycle counter load-from-preset strobe |
| status_clr | output | 1 | One-cycle status clear strobe |

## Verification
The hardest case to reach is a select period that carries more bytes than its instruction allows. One example is a read in which the host clocks in bytes that look like write data. Another is a narrow-width write followed by extra bytes. The output must stay zero and no register may move. A related case is a write cut short by the select line before its last byte, which must leave the target untouched. The bench builds these framings on purpose: its transfer task sends an arbitrary byte list for any instruction. Random passes then vary the width field, the preset data and the counter value, and predict every returned byte from the width rule.

// File: rtl/qspi_cmd_pkg.sv
package qspi_cmd_pkg;

  typedef enum logic [1:0] {
    OP_CLR = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_LD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    SEL_NONE_LO = 3'b000,
    SEL_CFG0    = 3'b001,
    SEL_CFG1    = 3'b010,
    SEL_PRE     = 3'b011,
    SEL_CNT     = 3'b100,
    SEL_SNAP    = 3'b101,
    SEL_STAT    = 3'b110,
    SEL_NONE_HI = 3'b111
  } sel_e;

  typedef enum logic [1:0] {
    PH_INSTR = 2'b00,
    PH_DATA  = 2'b01,
    PH_DONE  = 2'b10
  } phase_e;

  function automatic logic sel_is_wide(sel_e s);
    return (s == SEL_PRE) || (s == SEL_CNT) || (s == SEL_SNAP);
  endfunction

endpackage

// File: rtl/qspi_sync.sv
module qspi_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/qspi_frame.sv
module qspi_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       ss_s,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       tx_take,
  output logic       miso_bit
);

  logic       sck_d;
  logic [2:0] bitcnt_q, bitcnt_d;
  logic [6:0] rxsh_q, rxsh_d;
  logic [7:0] txsh_q, txsh_d;
  logic       done_q, done_d;
  logic [7:0] rxb_q, rxb_d;
  logic       rise, fall;

  assign rise    = !ss_s && sck_s && !sck_d;
  assign fall    = !ss_s && !sck_s && sck_d;
  assign tx_take = fall && (bitcnt_q == 3'd0);

  always_comb begin
    bitcnt_d = bitcnt_q;
    rxsh_d   = rxsh_q;
    txsh_d   = txsh_q;
    done_d   = 1'b0;
    rxb_d    = rxb_q;
    if (ss_s) begin
      bitcnt_d = 3'd0;
      txsh_d   = 8'h00;
    end else begin
      if (rise) begin
        rxsh_d   = {rxsh_q[5:0], mosi_s};
        bitcnt_d = bitcnt_q + 3'd1;
        if (bitcnt_q == 3'd7) begin
          done_d = 1'b1;
          rxb_d  = {rxsh_q, mosi_s};
        end
      end
      if (fall) begin
        if (bitcnt_q == 3'd0) txsh_d = tx_byte;
        else                  txsh_d = {txsh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      bitcnt_q <= 3'd0;
      rxsh_q   <= 7'd0;
      txsh_q   <= 8'h00;
      done_q   <= 1'b0;
      rxb_q    <= 8'h00;
    end else begin
      sck_d    <= sck_s;
      bitcnt_q <= bitcnt_d;
      rxsh_q   <= rxsh_d;
      txsh_q   <= txsh_d;
      done_q   <= done_d;
      rxb_q    <= rxb_d;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rxb_q;
  assign miso_bit  = txsh_q[7];

  // R1: a released select leaves framing and output idle
  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> (bitcnt_q == 3'd0 && txsh_q == 8'h00));

  // R3: a completed byte is reported for a single cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/qspi_exec.sv
module qspi_exec
  import qspi_cmd_pkg::*;
#(
  parameter int CNT_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ss_s,
  input  logic                   byte_done,
  input  logic [7:0]             rx_byte,
  input  logic                   tx_take,
  output logic [7:0]             tx_byte,
  input  logic [CNT_BYTES*8-1:0] cnt_in,
  input  logic [7:0]             status_in,
  output logic [7:0]             cfg0,
  output logic [7:0]             cfg1,
  output logic [CNT_BYTES*8-1:0] preset,
  output logic [CNT_BYTES*8-1:0] snap,
  output logic                   cnt_clr,
  output logic                   cnt_load,
  output logic                   status_clr
);

  localparam int CW  = CNT_BYTES * 8;
  localparam int NBW = $clog2(CNT_BYTES + 1);

  function automatic logic [NBW-1:0] nb_for(logic [1:0] code);
    int n;
    n = 4 - int'(code);
    if (n > CNT_BYTES) n = CNT_BYTES;
    return NBW'(n);
  endfunction

  phase_e         phase_q, phase_d;
  op_e            op_q, op_d;
  sel_e           sel_q, sel_d;
  logic [NBW-1:0] nb_q, nb_d, rxcnt_q, rxcnt_d, txcnt_q, txcnt_d;
  logic [CW-1:0]  acc_q, acc_d, rdbuf_q, rdbuf_d;
  logic [7:0]     cfg0_q, cfg0_d, cfg1_q, cfg1_d;
  logic [CW-1:0]  preset_q, preset_d, snap_q, snap_d;
  logic           cclr_q, cclr_d, cld_q, cld_d, sclr_q, sclr_d;

  op_e            dec_op;
  sel_e           dec_sel;
  logic [NBW-1:0] dec_nb;
  logic [CW-1:0]  rd_val, acc_nx;
  logic           tx_live;
  int             sh;

  assign dec_op  = op_e'(rx_byte[7:6]);
  assign dec_sel = sel_e'(rx_byte[5:3]);
  assign dec_nb  = sel_is_wide(dec_sel) ? nb_for(cfg1_q[1:0]) : NBW'(1);
  assign sh      = 8 * (CNT_BYTES - int'(dec_nb));
  assign acc_nx  = (acc_q << 8) | CW'(rx_byte);

  always_comb begin
    unique case (dec_sel)
      SEL_CFG0: rd_val = {cfg0_q, {(CW-8){1'b0}}};
      SEL_CFG1: rd_val = {cfg1_q, {(CW-8){1'b0}}};
      SEL_STAT: rd_val = {status_in, {(CW-8){1'b0}}};
      SEL_CNT:  rd_val = cnt_in << sh;
      SEL_SNAP: rd_val = snap_q << sh;
      default:  rd_val = '0;
    endcase
  end

  assign tx_live = (phase_q != PH_INSTR) && (op_q == OP_RD) && (txcnt_q < nb_q);
  assign tx_byte = tx_live ? rdbuf_q[CW-1 -: 8] : 8'h00;

  always_comb begin
    phase_d  = phase_q;
    op_d     = op_q;
    sel_d    = sel_q;
    nb_d     = nb_q;
    rxcnt_d  = rxcnt_q;
    txcnt_d  = txcnt_q;
    acc_d    = acc_q;
    rdbuf_d  = rdbuf_q;
    cfg0_d   = cfg0_q;
    cfg1_d   = cfg1_q;
    preset_d = preset_q;
    snap_d   = snap_q;
    cclr_d   = 1'b0;
    cld_d    = 1'b0;
    sclr_d   = 1'b0;
    if (ss_s) begin
      phase_d = PH_INSTR;
      rxcnt_d = '0;
      txcnt_d = '0;
      acc_d   = '0;
    end else begin
      if (byte_done) begin
        unique case (phase_q)
          PH_INSTR: begin
            op_d    = dec_op;
            sel_d   = dec_sel;
            nb_d    = dec_nb;
            rxcnt_d = '0;
            txcnt_d = '0;
            acc_d   = '0;
            rdbuf_d = '0;
            phase_d = (dec_op == OP_RD || dec_op == OP_WR) ? PH_DATA : PH_DONE;
            unique case (dec_op)
              OP_CLR: begin
                if (dec_sel == SEL_CFG0) cfg0_d = 8'h00;
                if (dec_sel == SEL_CFG1) cfg1_d = 8'h00;
                if (dec_sel == SEL_CNT)  cclr_d = 1'b1;
                if (dec_sel == SEL_STAT) sclr_d = 1'b1;
              end
              OP_RD: begin
                rdbuf_d = rd_val;
                if (dec_sel == SEL_CNT) snap_d = cnt_in;
              end
              OP_LD: begin
                if (dec_sel == SEL_CNT)  cld_d  = 1'b1;
                if (dec_sel == SEL_SNAP) snap_d = cnt_in;
              end
              default: ;
            endcase
          end
          PH_DATA: begin
            rxcnt_d = rxcnt_q + NBW'(1);
            if (op_q == OP_WR) acc_d = acc_nx;
            if (rxcnt_q + NBW'(1) == nb_q) begin
              phase_d = PH_DONE;
              if (op_q == OP_WR) begin
                if (sel_q == SEL_CFG0) cfg0_d   = rx_byte;
                if (sel_q == SEL_CFG1) cfg1_d   = rx_byte;
                if (sel_q == SEL_PRE)  preset_d = acc_nx;
              end
            end
          end
          default: ;
        endcase
      end
      if (tx_take && tx_live) begin
        rdbuf_d = rdbuf_q << 8;
        txcnt_d = txcnt_q + NBW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_INSTR;
      op_q     <= OP_CLR;
      sel_q    <= SEL_NONE_LO;
      nb_q     <= NBW'(1);
      rxcnt_q  <= '0;
      txcnt_q  <= '0;
      acc_q    <= '0;
      rdbuf_q  <= '0;
      cfg0_q   <= 8'h00;
      cfg1_q   <= 8'h00;
      preset_q <= '0;
      snap_q   <= '0;
      cclr_q   <= 1'b0;
      cld_q    <= 1'b0;
      sclr_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      op_q     <= op_d;
      sel_q    <= sel_d;
      nb_q     <= nb_d;
      rxcnt_q  <= rxcnt_d;
      txcnt_q  <= txcnt_d;
      acc_q    <= acc_d;
      rdbuf_q  <= rdbuf_d;
      cfg0_q   <= cfg0_d;
      cfg1_q   <= cfg1_d;
      preset_q <= preset_d;
      snap_q   <= snap_d;
      cclr_q   <= cclr_d;
      cld_q    <= cld_d;
      sclr_q   <= sclr_d;
    end
  end

  assign cfg0       = cfg0_q;
  assign cfg1       = cfg1_q;
  assign preset     = preset_q;
  assign snap       = snap_q;
  assign cnt_clr    = cclr_q;
  assign cnt_load   = cld_q;
  assign status_clr = sclr_q;

  // R4: preset moves only on the last byte of a write
  p_preset_wr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(preset_q) |-> $past(byte_done && phase_q == PH_DATA && op_q == OP_WR));

  // R5: capture register moves only when an instruction byte completes
  p_snap_at_instr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_q) |-> $past(byte_done && phase_q == PH_INSTR));

  // R3: data bytes never exceed the latched count
  p_rxcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (rxcnt_q < nb_q));

  // R7: at most one strobe at a time
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cclr_q, cld_q, sclr_q}));

  // R8: load strobe lasts one cycle
  p_load_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cld_q |=> !cld_q);

  // R9: read data leaves only while a read is live
  p_tx_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_RD) |-> (tx_byte == 8'h00));

endmodule

// File: rtl/qspi_cmd.sv
module qspi_cmd #(
  parameter int CNT_BYTES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck,
  input  logic                   ss_n,
  input  logic                   mosi,
  output logic                   miso,
  input  logic [CNT_BYTES*8-1:0] cnt_in,
  input  logic [7:0]             status_in,
  output logic [7:0]             cfg0,
  output logic [7:0]             cfg1,
  output logic [CNT_BYTES*8-1:0] preset,
  output logic [CNT_BYTES*8-1:0] snap,
  output logic                   cnt_clr,
  output logic                   cnt_load,
  output logic                   status_clr
);

  logic       rst_meta, rst_sn;
  logic [2:0] pins_s;
  logic       ss_s, sck_s, mosi_s;
  logic       byte_done, tx_take, miso_bit;
  logic [7:0] rx_byte, tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  qspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({ss_n, sck, mosi}),
    .q     (pins_s)
  );

  assign ss_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  qspi_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_sn),
    .sck_s     (sck_s),
    .ss_s      (ss_s),
    .mosi_s    (mosi_s),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_take   (tx_take),
    .miso_bit  (miso_bit)
  );

  qspi_exec #(.CNT_BYTES(CNT_BYTES)) u_exec (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ss_s       (ss_s),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .tx_take    (tx_take),
    .tx_byte    (tx_byte),
    .cnt_in     (cnt_in),
    .status_in  (status_in),
    .cfg0       (cfg0),
    .cfg1       (cfg1),
    .preset     (preset),
    .snap       (snap),
    .cnt_clr    (cnt_clr),
    .cnt_load   (cnt_load),
    .status_clr (status_clr)
  );

  assign miso = ss_n ? 1'bz : miso_bit;

endmodule

// File: tb/qspi_cmd_bench.sv
module qspi_cmd_bench;

  localparam int CLK_NS = 10;
  localparam int HALF   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        ss_n = 1'b1;
  logic        mosi = 1'b0;
  wire         miso;
  logic [31:0] cnt_in = '0;
  logic [7:0]  status_in = '0;
  logic [7:0]  cfg0, cfg1;
  logic [31:0] preset, snap;
  logic        cnt_clr, cnt_load, status_clr;

  int vectors = 0;
  int fails = 0;
  int n_clr = 0, n_ld = 0, n_sclr = 0;
  logic [7:0] tx_b [0:5];
  logic [7:0] rx_b [0:5];

  always #(CLK_NS/2) clk = ~clk;

  qspi_cmd u_qspi_cmd (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .cnt_in(cnt_in), .status_in(status_in), .cfg0(cfg0), .cfg1(cfg1),
    .preset(preset), .snap(snap), .cnt_clr(cnt_clr), .cnt_load(cnt_load),
    .status_clr(status_clr)
  );

  always @(posedge clk) begin
    if (cnt_clr)    n_clr++;
    if (cnt_load)   n_ld++;
    if (status_clr) n_sclr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_nb(input logic [1:0] code);
    return 4 - int'(code);
  endfunction

  function automatic logic [7:0] exp_rd_byte(input logic [31:0] v, input int nb, input int i);
    if (i >= nb) return 8'h00;
    return 8'((v >> (8 * (nb - 1 - i))) & 32'hFF);
  endfunction

  task automatic xfer(input int nbytes);
    @(negedge clk); ss_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tx_b[b][i];
        repeat (HALF) @(negedge clk);
        rx_b[b][i] = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    ss_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic fill(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input logic [7:0] b4);
    tx_b[0] = b0; tx_b[1] = b1; tx_b[2] = b2; tx_b[3] = b3; tx_b[4] = b4; tx_b[5] = 8'hFF;
  endtask

  initial begin
    #(CLK_NS * 190000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int c_clr, c_ld, c_sclr;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R10 reset state, R1 idle output
    chk("R10 cfg0", 32'(cfg0), 32'h0);
    chk("R10 cfg1", 32'(cfg1), 32'h0);
    chk("R10 preset", preset, 32'h0);
    chk("R10 snap", snap, 32'h0);
    chk("R10 strobes", 32'(n_clr + n_ld + n_sclr), 32'h0);
    chk("R1 miso z idle", 32'(miso === 1'bz), 32'h1);

    // R4 write cfg0
    fill(8'h88, 8'h5A, 8'h00, 8'h00, 8'h00); xfer(2);
    chk("R4 write cfg0", 32'(cfg0), 32'h5A);
    // R2 low instruction bits ignored
    fill(8'h8F, 8'hC3, 8'h00, 8'h00, 8'h00); xfer(2);
    chk("R2 low bits ignored", 32'(cfg0), 32'hC3);

    // R6/R1/R9 read cfg0 with MOSI busy
    fill(8'h48, 8'hFF, 8'hFF, 8'h00, 8'h00); xfer(3);
    chk("R1 zero during instruction", 32'(rx_b[0]), 32'h0);
    chk("R6 read cfg0", 32'(rx_b[1]), 32'hC3);
    chk("R9 extra byte zero", 32'(rx_b[2]), 32'h0);
    chk("R9 mosi ignored on read", 32'(cfg0), 32'hC3);

    // R3 width 2 bytes
    fill(8'h90, 8'h02, 8'h00, 8'h00, 8'h00); xfer(2);
    chk("R4 write cfg1", 32'(cfg1), 32'h02);
    fill(8'h98, 8'hAB, 8'hCD, 8'h11, 8'h22); xfer(5);
    chk("R3 preset MSB first two bytes", preset, 32'h0000ABCD);

    // R4 aborted write
    fill(8'h98, 8'h77, 8'h00, 8'h00, 8'h00); xfer(2);
    chk("R4 aborted write", preset, 32'h0000ABCD);

    // R5 counter read snapshot
    cnt_in = 32'h12345678;
    fill(8'h60, 8'h00, 8'h00, 8'h00, 8'h00); xfer(4);
    chk("R5 read cnt byte1", 32'(rx_b[1]), 32'h56);
    chk("R5 read cnt byte2", 32'(rx_b[2]), 32'h78);
    chk("R3 read beyond width", 32'(rx_b[3]), 32'h0);
    chk("R5 snapshot", snap, 32'h12345678);

    // R6 read capture, not live counter
    cnt_in = 32'hCAFEF00D;
    fill(8'h68, 8'h00, 8'h00, 8'h00, 8'h00); xfer(3);
    chk("R6 read snap byte1", 32'(rx_b[1]), 32'h56);
    chk("R6 read snap byte2", 32'(rx_b[2]), 32'h78);
    chk("R6 snap held", snap, 32'h12345678);

    // R8 load capture, load counter, load cfg1
    fill(8'hE8, 8'h00, 8'h00, 8'h00, 8'h00); xfer(1);
    chk("R8 load snap", snap, 32'hCAFEF00D);
    c_ld = n_ld;
    fill(8'hE0, 8'h00, 8'h00, 8'h00, 8'h00); xfer(1);
    chk("R8 cnt_load pulse", 32'(n_ld - c_ld), 32'h1);
    chk("R8 preset kept", preset, 32'h0000ABCD);
    fill(8'hD0, 8'h00, 8'h00, 8'h00, 8'h00); xfer(1);
    chk("R8 load cfg1 no effect", 32'(cfg1), 32'h02);

    // R7 clears
    c_clr = n_clr; c_sclr = n_sclr;
    fill(8'h20, 8'h00, 8'h00, 8'h00, 8'h00); xfer(1);
    chk("R7 cnt_clr pulse", 32'(n_clr - c_clr), 32'h1);
    fill(8'h30, 8'h00, 8'h00, 8'h00, 8'h00); xfer(1);
    chk("R7 status_clr pulse", 32'(n_sclr - c_sclr), 32'h1);
    fill(8'h18, 8'h00, 8'h00, 8'h00, 8'h00); xfer(1);
    chk("R7 clear preset no effect", preset, 32'h0000ABCD);
    fill(8'h28, 8'h00, 8'h00, 8'h00, 8'h00); xfer(1);
    chk("R7 clear snap no effect", snap, 32'hCAFEF00D);
    fill(8'h08, 8'hFF, 8'h00, 8'h00, 8'h00); xfer(2);
    chk("R7 clear cfg0", 32'(cfg0), 32'h0);
    chk("R9 byte after clear ignored", 32'(cfg0), 32'h0);

    // R4 writes with no target
    c_clr = n_clr; c_ld = n_ld; c_sclr = n_sclr;
    fill(8'hA8, 8'h11, 8'h22, 8'h00, 8'h00); xfer(3);
    chk("R4 write snap no effect", snap, 32'hCAFEF00D);
    fill(8'hA0, 8'h11, 8'h22, 8'h00, 8'h00); xfer(3);
    fill(8'hB0, 8'h11, 8'h00, 8'h00, 8'h00); xfer(2);
    chk("R4 write cnt/status no strobe", 32'((n_clr - c_clr) + (n_ld - c_ld) + (n_sclr - c_sclr)), 32'h0);

    // R6 status, preset, none
    status_in = 8'h96;
    fill(8'h70, 8'h00, 8'h00, 8'h00, 8'h00); xfer(3);
    chk("R6 read status", 32'(rx_b[1]), 32'h96);
    chk("R6 status one byte", 32'(rx_b[2]), 32'h0);
    fill(8'h58, 8'h00, 8'h00, 8'h00, 8'h00); xfer(3);
    chk("R6 read preset zero", 32'({rx_b[1], rx_b[2]}), 32'h0);
    fill(8'h40, 8'h00, 8'h00, 8'h00, 8'h00); xfer(2);
    chk("R6 read none zero", 32'(rx_b[1]), 32'h0);
    chk("R1 miso z after", 32'(miso === 1'bz), 32'h1);

    // random passes: R3 R4 R5
    for (int it = 0; it < 24; it++) begin
      logic [7:0]  c1;
      logic [31:0] v, m;
      int nb;
      c1 = 8'($urandom);
      fill(8'h90, c1, 8'h00, 8'h00, 8'h00); xfer(2);
      chk("R4 random cfg1", 32'(cfg1), 32'(c1));
      nb = exp_nb(c1[1:0]);
      v = $urandom;
      m = (nb == 4) ? 32'hFFFFFFFF : ((32'h1 << (8*nb)) - 32'h1);
      fill(8'h98, exp_rd_byte(v, nb, 0), exp_rd_byte(v, nb, 1),
           exp_rd_byte(v, nb, 2), exp_rd_byte(v, nb, 3));
      xfer(5);
      chk("R3 random preset width", preset, v & m);
      cnt_in = $urandom;
      fill(8'h60 | 8'($urandom % 8), 8'hA5, 8'h5A, 8'hFF, 8'h00); xfer(nb + 2);
      for (int i = 0; i <= nb; i++)
        chk("R5 random counter byte", 32'(rx_b[1 + i]), 32'(exp_rd_byte(cnt_in, nb, i)));
      chk("R5 random snapshot", snap, cnt_in);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule